// File: doc/BRIEF.md
# TDM Frame Buffer and Register Block

This block is the host-facing side of a time-division-multiplexed slot engine. An 8-bit bus slave with a 3-bit address lets a CPU load outgoing bytes into a 32-entry transmit queue, drain incoming bytes from a 32-entry receive queue, and set the control bits and the channel count that the slot engine uses. Each queue holds one whole 32-slot frame. The bus follows single-cycle Wishbone classic accesses. A write to a full transmit queue, or a read from an empty receive queue, is answered with a retry instead of an acknowledge.

On the engine side, the slot engine pulls one transmit byte per request and pushes one receive byte per strobe. When transmission is enabled and the transmit queue is not empty, the byte offered to the engine is the oldest queued byte. Otherwise it is the idle pattern 0xFF. Two tag outputs act as level interrupts: one means "transmit queue empty" and the other means "receive queue holds data". The engine and the bus share one clock.

Top module: `tdm_buf_regs`

## Requirements
- R1: While `rst_i` is high, and after it falls, offset 0 reads 0x01, offset 2 reads 0x00 and offset 4 reads 0xFF. `tx_enable_o` and `hdlc_en_o` are 0, and both queues are empty.
- R2: `ack_o` or `rty_o` rises in the cycle after `cyc_i` and `stb_i` are both high. It stays high for exactly one cycle per access, and `ack_o` and `rty_o` are never high together.
- R3: A write to offset 1 appends `dat_i` to the transmit queue and is acknowledged. When the queue already holds 32 bytes, the write gets `rty_o` and the queue is unchanged.
- R4: A read of offset 3 returns the oldest received byte on `dat_o` with `ack_o` and removes it. When the receive queue is empty, the read gets `rty_o` and nothing changes.
- R5: Offset 0 layout. Bit 0 (read) is 1 when the transmit queue is empty. Bit 1 (write) sets transmit enable, driven on `tx_enable_o`. Bit 2 (read) is the underrun flag. Bit 3 (write) sets `hdlc_en_o`. Write-only bits read back as 0.
- R6: Offset 2 layout. Bit 0 (read) is 1 when the receive queue holds 32 bytes. Bit 2 (read) is a sticky frame-error flag, set by `eng_frame_err_i`. Writing 1 to bit 1 empties the receive queue and clears the frame-error flag. Bit 1 reads back as 0.
- R7: Offset 4 is a read/write channel count that resets to 0xFF and is driven on `chan_count_o`.
- R8: `tag_txdone_o` is high exactly when the transmit queue is empty. `tag_rxrdy_o` is high exactly when the receive queue is not empty.
- R9: `eng_tx_data_o` shows the oldest transmit byte when transmit is enabled and the queue is not empty, and 0xFF otherwise. A high `eng_tx_req_i` removes that byte only in the first case, so with transmit disabled the queue is untouched.
- R10: `eng_tx_req_i` with transmit enabled and an empty queue sets the underrun flag. Any write to offset 0 clears it.
- R11: `eng_rx_we_i` appends `eng_rx_data_i` to the receive queue. When the queue holds 32 bytes, the byte is discarded.
- R12: Reads of offsets 1 and 5 to 7 return 0x00 with `ack_o`. Writes to offsets 3 and 5 to 7 are acknowledged and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared bus and engine clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | 3 | Register offset |
| dat_i | input | 8 | Write data |
| dat_o | output | 8 | Read data, valid with `ack_o` |
| ack_o | output | 1 | Access acknowledge |
| rty_o | output | 1 | Retry: queue full on write or empty on read |
| tag_txdone_o | output | 1 | Transmit queue empty interrupt |
| tag_rxrdy_o | output | 1 | Receive queue has data interrupt |
| eng_tx_req_i | input | 1 | Engine takes one transmit byte |
| eng_tx_data_o | output | 8 | Byte offered to the engine (0xFF when idle) |
| eng_rx_we_i | input | 1 | Engine delivers one receive byte |
| eng_rx_data_i | input | 8 | Received byte from the engine |
| eng_frame_err_i | input | 1 | Engine reports a frame error |
| tx_enable_o | output | 1 | Transmit enable control bit |
| hdlc_en_o | output | 1 | HDLC routing control bit |
| chan_count_o | output | 8 | Configured number of channels |

## Verification
A corrupted queue pointer or count first shows up on the tags and the status bits, at the next register read. A pointer error shows up on `dat_o` or `eng_tx_data_o` as a byte that is out of order or was never written, at the very next pop. A lost acknowledge or a doubled acknowledge appears at the bus ports one cycle after the strobe. A stuck sticky flag shows on the next status read after its clear. The bench keeps a byte-exact model of both queues and compares every popped byte, every retry and every status read against it, so a fault is reported within the access that exposes it.

// File: rtl/tdm_buf_pkg.sv
package tdm_buf_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 3;
    localparam int FIFO_DEPTH = 32;

    localparam logic [ADDR_W-1:0] OFS_TX_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_TX_DATA = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_RX_CTRL = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_RX_DATA = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_CHAN    = 3'd4;

    // bit positions shared by both control/status registers
    localparam int BIT_LEVEL = 0;   // queue level flag (read)
    localparam int BIT_CMD   = 1;   // enable / drop (write)
    localparam int BIT_FLAG  = 2;   // sticky flag (read)
    localparam int BIT_HDLC  = 3;   // hdlc routing (write)

    localparam logic [DATA_W-1:0] CHAN_RESET = 8'hFF;
    localparam logic [DATA_W-1:0] IDLE_BYTE  = 8'hFF;
endpackage

// File: rtl/tdm_byte_fifo.sv
module tdm_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 32
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic                          flush_i,
    input  logic                          push_i,
    input  logic [WIDTH-1:0]              push_data_i,
    input  logic                          pop_i,
    output logic [WIDTH-1:0]              head_o,
    output logic [$clog2(DEPTH+1)-1:0]    count_o,
    output logic                          empty_o,
    output logic                          full_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign empty_o = (s_q.cnt == '0);
    assign full_o  = (s_q.cnt == CNT_W'(DEPTH));
    assign do_push = push_i && !full_o && !flush_i;
    assign do_pop  = pop_i && !empty_o && !flush_i;
    assign head_o  = mem_q[s_q.rd];
    assign count_o = s_q.cnt;

    always_comb begin
        s_d = s_q;
        if (flush_i) begin
            s_d = '0;
        end else begin
            if (do_push) s_d.wr = (s_q.wr == LAST) ? '0 : s_q.wr + 1'b1;
            if (do_pop)  s_d.rd = (s_q.rd == LAST) ? '0 : s_q.rd + 1'b1;
            s_d.cnt = s_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    always_ff @(posedge clk_i) begin
        if (do_push) mem_q[s_q.wr] <= push_data_i;
    end
endmodule

// File: rtl/tdm_wb_regs.sv
module tdm_wb_regs
    import tdm_buf_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cyc_i,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] adr_i,
    input  logic [DATA_W-1:0] dat_i,
    output logic [DATA_W-1:0] dat_o,
    output logic              ack_o,
    output logic              rty_o,
    input  logic              tx_full_i,
    input  logic              tx_empty_i,
    input  logic              rx_full_i,
    input  logic              rx_empty_i,
    input  logic [DATA_W-1:0] rx_head_i,
    input  logic              eng_tx_req_i,
    input  logic              eng_frame_err_i,
    output logic              tx_push_o,
    output logic              rx_pop_o,
    output logic              rx_flush_o,
    output logic              tx_en_o,
    output logic              hdlc_en_o,
    output logic [DATA_W-1:0] chan_o
);
    typedef struct packed {
        logic              ack;
        logic              rty;
        logic [DATA_W-1:0] dat;
        logic              tx_en;
        logic              hdlc_en;
        logic              aborted;
        logic              frame_err;
        logic [DATA_W-1:0] chan;
    } regs_t;

    regs_t r_d, r_q;
    logic  req, clr_abort;

    assign req = cyc_i && stb_i && !r_q.ack && !r_q.rty;

    always_comb begin
        r_d        = r_q;
        r_d.ack    = 1'b0;
        r_d.rty    = 1'b0;
        r_d.dat    = '0;
        tx_push_o  = 1'b0;
        rx_pop_o   = 1'b0;
        rx_flush_o = 1'b0;
        clr_abort  = 1'b0;
        if (req) begin
            r_d.ack = 1'b1;
            unique case (adr_i)
                OFS_TX_CTRL: begin
                    if (we_i) begin
                        r_d.tx_en   = dat_i[BIT_CMD];
                        r_d.hdlc_en = dat_i[BIT_HDLC];
                        clr_abort   = 1'b1;
                    end else begin
                        r_d.dat[BIT_LEVEL] = tx_empty_i;
                        r_d.dat[BIT_FLAG]  = r_q.aborted;
                    end
                end
                OFS_TX_DATA: begin
                    if (we_i) begin
                        if (tx_full_i) begin
                            r_d.ack = 1'b0;
                            r_d.rty = 1'b1;
                        end else begin
                            tx_push_o = 1'b1;
                        end
                    end
                end
                OFS_RX_CTRL: begin
                    if (we_i) begin
                        rx_flush_o = dat_i[BIT_CMD];
                    end else begin
                        r_d.dat[BIT_LEVEL] = rx_full_i;
                        r_d.dat[BIT_FLAG]  = r_q.frame_err;
                    end
                end
                OFS_RX_DATA: begin
                    if (!we_i) begin
                        if (rx_empty_i) begin
                            r_d.ack = 1'b0;
                            r_d.rty = 1'b1;
                        end else begin
                            rx_pop_o = 1'b1;
                            r_d.dat  = rx_head_i;
                        end
                    end
                end
                OFS_CHAN: begin
                    if (we_i) r_d.chan = dat_i;
                    else      r_d.dat  = r_q.chan;
                end
                default: ;
            endcase
        end
        if (eng_tx_req_i && r_q.tx_en && tx_empty_i) r_d.aborted = 1'b1;
        else if (clr_abort)                          r_d.aborted = 1'b0;
        if (eng_frame_err_i)  r_d.frame_err = 1'b1;
        else if (rx_flush_o)  r_d.frame_err = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q      <= '0;
            r_q.chan <= CHAN_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign dat_o     = r_q.dat;
    assign ack_o     = r_q.ack;
    assign rty_o     = r_q.rty;
    assign tx_en_o   = r_q.tx_en;
    assign hdlc_en_o = r_q.hdlc_en;
    assign chan_o    = r_q.chan;
endmodule

// File: rtl/tdm_buf_regs.sv
module tdm_buf_regs
    import tdm_buf_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cyc_i,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] adr_i,
    input  logic [DATA_W-1:0] dat_i,
    output logic [DATA_W-1:0] dat_o,
    output logic              ack_o,
    output logic              rty_o,
    output logic              tag_txdone_o,
    output logic              tag_rxrdy_o,
    input  logic              eng_tx_req_i,
    output logic [DATA_W-1:0] eng_tx_data_o,
    input  logic              eng_rx_we_i,
    input  logic [DATA_W-1:0] eng_rx_data_i,
    input  logic              eng_frame_err_i,
    output logic              tx_enable_o,
    output logic              hdlc_en_o,
    output logic [DATA_W-1:0] chan_count_o
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_push, tx_pop, rx_pop, rx_flush, tx_en;
    logic [DATA_W-1:0] tx_head, rx_head;
    logic [CNT_W-1:0]  tx_count, rx_count;
    logic              tx_live;

    assign tx_live = tx_en && !tx_empty;
    assign tx_pop  = eng_tx_req_i && tx_live;

    tdm_byte_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .flush_i    (1'b0),
        .push_i     (tx_push),
        .push_data_i(dat_i),
        .pop_i      (tx_pop),
        .head_o     (tx_head),
        .count_o    (tx_count),
        .empty_o    (tx_empty),
        .full_o     (tx_full)
    );

    tdm_byte_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .flush_i    (rx_flush),
        .push_i     (eng_rx_we_i),
        .push_data_i(eng_rx_data_i),
        .pop_i      (rx_pop),
        .head_o     (rx_head),
        .count_o    (rx_count),
        .empty_o    (rx_empty),
        .full_o     (rx_full)
    );

    tdm_wb_regs u_regs (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .cyc_i          (cyc_i),
        .stb_i          (stb_i),
        .we_i           (we_i),
        .adr_i          (adr_i),
        .dat_i          (dat_i),
        .dat_o          (dat_o),
        .ack_o          (ack_o),
        .rty_o          (rty_o),
        .tx_full_i      (tx_full),
        .tx_empty_i     (tx_empty),
        .rx_full_i      (rx_full),
        .rx_empty_i     (rx_empty),
        .rx_head_i      (rx_head),
        .eng_tx_req_i   (eng_tx_req_i),
        .eng_frame_err_i(eng_frame_err_i),
        .tx_push_o      (tx_push),
        .rx_pop_o       (rx_pop),
        .rx_flush_o     (rx_flush),
        .tx_en_o        (tx_en),
        .hdlc_en_o      (hdlc_en_o),
        .chan_o         (chan_count_o)
    );

    assign tx_enable_o   = tx_en;
    assign eng_tx_data_o = tx_live ? tx_head : IDLE_BYTE;
    assign tag_txdone_o  = tx_empty;
    assign tag_rxrdy_o   = !rx_empty;
endmodule

// File: rtl/tdm_buf_checker.sv
module tdm_buf_checker #(
    parameter int CNT_W = 6,
    parameter int DEPTH = 32
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             cyc_i,
    input logic             stb_i,
    input logic             we_i,
    input logic [2:0]       adr_i,
    input logic [7:0]       dat_i,
    input logic             ack_o,
    input logic             rty_o,
    input logic             tag_txdone_o,
    input logic             tag_rxrdy_o,
    input logic             eng_rx_we_i,
    input logic [7:0]       eng_tx_data_o,
    input logic             tx_full,
    input logic             rx_empty,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count
);
    assert_ack_rty_excl_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !(ack_o && rty_o));

    assert_resp_after_req_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_o || rty_o) |-> $past(cyc_i && stb_i));

    assert_single_ack_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_o || rty_o) |=> !(ack_o || rty_o));

    assert_tx_full_retry_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc_i && stb_i && we_i && adr_i == 3'd1 && tx_full && !ack_o && !rty_o) |=> rty_o);

    assert_rx_empty_retry_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc_i && stb_i && !we_i && adr_i == 3'd3 && rx_empty && !ack_o && !rty_o) |=> rty_o);

    assert_drop_empties_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_o && $past(we_i && adr_i == 3'd2 && dat_i[1])) |-> !tag_rxrdy_o);

    assert_rx_tag_source_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(tag_rxrdy_o) |-> $past(eng_rx_we_i));

    assert_idle_ones_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        tag_txdone_o |-> (eng_tx_data_o == 8'hFF));

    assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (tx_count <= CNT_W'(DEPTH)) && (rx_count <= CNT_W'(DEPTH)));
endmodule

bind tdm_buf_regs tdm_buf_checker #(.CNT_W(CNT_W), .DEPTH(tdm_buf_pkg::FIFO_DEPTH)) u_checker (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .cyc_i        (cyc_i),
    .stb_i        (stb_i),
    .we_i         (we_i),
    .adr_i        (adr_i),
    .dat_i        (dat_i),
    .ack_o        (ack_o),
    .rty_o        (rty_o),
    .tag_txdone_o (tag_txdone_o),
    .tag_rxrdy_o  (tag_rxrdy_o),
    .eng_rx_we_i  (eng_rx_we_i),
    .eng_tx_data_o(eng_tx_data_o),
    .tx_full      (tx_full),
    .rx_empty     (rx_empty),
    .tx_count     (tx_count),
    .rx_count     (rx_count)
);

// File: tb/tdm_buf_regs_bench.sv
module tdm_buf_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;

    logic       clk = 1'b0;
    logic       rst;
    logic       cyc, stb, we;
    logic [2:0] adr;
    logic [7:0] wdat;
    logic [7:0] rdat;
    logic       ack, rty, tag_tx, tag_rx;
    logic       tx_req, rx_we, ferr;
    logic [7:0] tx_data, rx_data;
    logic       tx_en_o, hdlc_o;
    logic [7:0] chan_o;

    int checks = 0;
    int fails  = 0;

    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    bit         m_en, m_abort, m_ferr;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_buf_regs u_tdm_buf_regs (
        .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
        .adr_i(adr), .dat_i(wdat), .dat_o(rdat), .ack_o(ack), .rty_o(rty),
        .tag_txdone_o(tag_tx), .tag_rxrdy_o(tag_rx),
        .eng_tx_req_i(tx_req), .eng_tx_data_o(tx_data),
        .eng_rx_we_i(rx_we), .eng_rx_data_i(rx_data), .eng_frame_err_i(ferr),
        .tx_enable_o(tx_en_o), .hdlc_en_o(hdlc_o), .chan_count_o(chan_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_tx_status();
        return {5'b0, m_abort, 1'b0, (txq.size() == 0)};
    endfunction

    function automatic logic [7:0] exp_rx_status();
        return {5'b0, m_ferr, 1'b0, (rxq.size() == DEPTH)};
    endfunction

    function automatic logic [7:0] exp_eng_byte();
        return (m_en && txq.size() != 0) ? txq[0] : 8'hFF;
    endfunction

    // one bus access: request at negedge, response sampled at the next negedge
    task automatic bus(input bit w, input logic [2:0] a, input logic [7:0] d,
                       output bit got_ack, output bit got_rty, output logic [7:0] got_dat);
        @(negedge clk);
        cyc = 1; stb = 1; we = w; adr = a; wdat = d;
        @(negedge clk);
        got_ack = ack; got_rty = rty; got_dat = rdat;
        cyc = 0; stb = 0; we = 0;
    endtask

    task automatic reg_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
        bit k, r; logic [7:0] v;
        bus(0, a, 8'h00, k, r, v);
        check({tag, " ack"}, k, 1);
        check({tag, " data"}, v, exp);
    endtask

    task automatic tx_write(input logic [7:0] d, input string tag);
        bit k, r; logic [7:0] v;
        bit full = (txq.size() == DEPTH);
        bus(1, 3'd1, d, k, r, v);
        check({tag, " ack"}, k, !full);
        check({tag, " rty"}, r, full);
        if (!full) txq.push_back(d);
    endtask

    task automatic rx_read(input string tag);
        bit k, r; logic [7:0] v;
        bit empty = (rxq.size() == 0);
        bus(0, 3'd3, 8'h00, k, r, v);
        check({tag, " rty"}, r, empty);
        check({tag, " ack"}, k, !empty);
        if (!empty) begin
            check({tag, " data"}, v, rxq[0]);
            void'(rxq.pop_front());
        end
    endtask

    task automatic ctrl_write(input logic [7:0] d);
        bit k, r; logic [7:0] v;
        bus(1, 3'd0, d, k, r, v);
        m_en = d[1];
        m_abort = 0;
    endtask

    task automatic eng_push(input logic [7:0] d);
        @(negedge clk);
        rx_we = 1; rx_data = d;
        @(negedge clk);
        rx_we = 0;
        if (rxq.size() < DEPTH) rxq.push_back(d);
    endtask

    task automatic eng_pull(input string tag);
        @(negedge clk);
        check({tag, " engine byte"}, tx_data, exp_eng_byte());
        tx_req = 1;
        @(negedge clk);
        tx_req = 0;
        if (m_en && txq.size() != 0) void'(txq.pop_front());
        else if (m_en) m_abort = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit k, r; logic [7:0] v;
        void'($urandom(32'd20250611));
        rst = 1; cyc = 0; stb = 0; we = 0; adr = 0; wdat = 0;
        tx_req = 0; rx_we = 0; rx_data = 0; ferr = 0;
        m_en = 0; m_abort = 0; m_ferr = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state, R8 tags, R9 idle byte
        reg_read(3'd0, 8'h01, "R1 tx status");
        reg_read(3'd2, 8'h00, "R1 rx status");
        reg_read(3'd4, 8'hFF, "R1 chan reset");
        check("R1 tx_enable", tx_en_o, 0);
        check("R8 tag tx after reset", tag_tx, 1);
        check("R8 tag rx after reset", tag_rx, 0);
        check("R9 idle byte", tx_data, 8'hFF);

        // R2 timing: response one cycle after request, one cycle long
        @(negedge clk);
        cyc = 1; stb = 1; we = 0; adr = 3'd4;
        check("R2 no ack in request cycle", ack, 0);
        @(negedge clk);
        check("R2 ack after one cycle", ack, 1);
        @(negedge clk);
        check("R2 ack one cycle wide", ack, 0);
        cyc = 0; stb = 0;

        // R12 unused offsets and write-only ports
        reg_read(3'd1, 8'h00, "R12 read tx port");
        reg_read(3'd6, 8'h00, "R12 read offset 6");
        bus(1, 3'd7, 8'h5A, k, r, v);
        check("R12 write offset 7 ack", k, 1);
        bus(1, 3'd3, 8'h5A, k, r, v);
        check("R12 write rx port ack", k, 1);
        check("R12 rx tag unchanged", tag_rx, 0);

        // R5 control layout
        ctrl_write(8'h0A);
        check("R5 tx_enable_o", tx_en_o, 1);
        check("R5 hdlc_en_o", hdlc_o, 1);
        reg_read(3'd0, 8'h01, "R5 write-only bits read 0");

        // R10 underrun flag
        eng_pull("R10 underrun pull");
        reg_read(3'd0, exp_tx_status(), "R10 aborted set");
        ctrl_write(8'h02);
        reg_read(3'd0, exp_tx_status(), "R10 aborted cleared");

        // R3 fill transmit queue with engine disabled (R9)
        ctrl_write(8'h00);
        for (int i = 0; i < DEPTH; i++) tx_write(8'(i * 7 + 3), "R3 fill");
        check("R8 tag tx full queue", tag_tx, 0);
        tx_write(8'hEE, "R3 overfull write");
        eng_pull("R9 disabled pull");
        check("R9 disabled idle byte", tx_data, 8'hFF);
        ctrl_write(8'h02);
        for (int i = 0; i < DEPTH; i++) eng_pull("R9 drain order");
        check("R8 tag tx drained", tag_tx, 1);

        // R11 receive fill and overflow, R6 frame error and drop
        for (int i = 0; i < DEPTH + 2; i++) eng_push(8'(8'hA0 ^ i));
        reg_read(3'd2, exp_rx_status(), "R6 rx full flag");
        check("R8 tag rx", tag_rx, 1);
        rx_read("R11 oldest kept");
        @(negedge clk); ferr = 1; @(negedge clk); ferr = 0; m_ferr = 1;
        reg_read(3'd2, exp_rx_status(), "R6 frame error");
        bus(1, 3'd2, 8'h02, k, r, v);
        rxq.delete(); m_ferr = 0;
        check("R6 drop empties", tag_rx, 0);
        reg_read(3'd2, 8'h00, "R6 after drop");
        rx_read("R4 empty retry");

        // R7 channel count
        bus(1, 3'd4, 8'h1F, k, r, v);
        reg_read(3'd4, 8'h1F, "R7 readback");
        check("R7 chan output", chan_o, 8'h1F);

        // random mix
        for (int n = 0; n < 1500; n++) begin
            int op = $urandom % 8;
            case (op)
                0, 1: tx_write(8'($urandom), "R3 random write");
                2, 3: eng_push(8'($urandom));
                4:    rx_read("R4 random read");
                5:    eng_pull("R9 random pull");
                6:    begin
                          reg_read(3'd0, exp_tx_status(), "R5 random tx status");
                          reg_read(3'd2, exp_rx_status(), "R6 random rx status");
                      end
                default: begin
                          check("R8 random tag tx", tag_tx, txq.size() == 0);
                          check("R8 random tag rx", tag_rx, rxq.size() != 0);
                          if (($urandom % 4) == 0) ctrl_write($urandom % 2 ? 8'h02 : 8'h00);
                      end
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule